// File: doc/BRIEF.md
# UART Loopback Self-Test Controller

This block sequences a built-in self-test of a UART. Software starts it by writing a byte with bit 7 set into an 8-bit control and result register. The controller then closes an internal loopback from the transmitter output to the receiver input. It pulls a block of generated bytes from a pattern source and pushes each one into the transmit FIFO. It waits for the transmitter to drain and for the receive FIFO to hold the whole block. Finally it pops the received bytes and checks them, in order, against a private copy of what it sent.

Each phase sets its own progress bit in the register as it completes. If a run fails, the last progress bit that was set shows how far the run got. A sticky bit records any receiver error pulse seen during the run. Bit 0 carries the pass/fail verdict. A frame-time watchdog ends a run that stalls while waiting on the serial path. The UART datapath and the pattern source connect through simple strobe ports.

Top module: `uart_selftest_ctrl`

## Requirements
- R1: A write with data bit 7 = 1 while no test is running sets the register to 0x80 on the next cycle, clearing bits 6..0. `loop_en` is 1 for as long as bit 7 is 1.
- R2: While loading, the controller asserts `pat_req`. For every cycle with `pat_vld` it pushes `pat_data` into the transmit FIFO, for exactly DEPTH pushes. Bit 6 is set after the last push, while bit 5 is still 0.
- R3: After loading, bit 5 is set once `tx_idle` is 1, meaning the transmit FIFO and shifter are empty.
- R4: Once `rxf_count` reaches DEPTH, bits 4 and 3 are set together and the comparison phase starts.
- R5: During comparison the controller pops exactly DEPTH bytes. It compares each popped byte with the byte pushed in the same position. Bit 0 ends at 1 only if every byte matched, and a single mismatch leaves it at 0.
- R6: Bit 2 is set and held if `rx_err` is 1 in any cycle of a run. It does not change bit 0.
- R7: If the receive FIFO has not filled within FRAME_CYC*(DEPTH+FRAME_SLACK) cycles of the send phase starting, the run ends with bits 4, 3 and 0 at 0.
- R8: Bit 7 clears when a run ends. The result bits then hold unchanged until the next start.
- R9: Writes while a run is active, and writes with bit 7 = 0, leave the register unchanged.
- R10: Bit 1 always reads 0.
- R11: After reset the register reads 0x00, and `loop_en`, `txf_push` and `rxf_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| cfg_rd_data | output | 8 | Control and result register readback |
| loop_en | output | 1 | Internal loopback enable for the UART |
| pat_req | output | 1 | Request for the next generated pattern |
| pat_vld | input | 1 | Pattern source has a byte on pat_data |
| pat_data | input | DW | Generated pattern byte |
| txf_push | output | 1 | Push strobe into the transmit FIFO |
| txf_data | output | DW | Byte pushed into the transmit FIFO |
| tx_idle | input | 1 | Transmit FIFO empty and shifter idle |
| rxf_count | input | CNT_W | Receive FIFO fill level |
| rxf_data | input | DW | Head byte of the receive FIFO |
| rxf_pop | output | 1 | Pop strobe for the receive FIFO |
| rx_err | input | 1 | Any receiver error flag (parity, framing, overrun, break) |

## Verification
The hardest outcomes to reach from the ports are the partial failures: a run that stops after bit 5, or a run where exactly one byte in a chosen position comes back wrong. The bench places a behavioural UART with loopback around the controller. Each vector can drop, corrupt or flag one byte at a chosen index, including the first and last positions. Some vectors also stall the pattern source every other cycle, so that pushes and serial transmission overlap in different ways.

// File: rtl/ubist_pkg.sv
package ubist_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LOAD = 3'd1,
        PH_SEND = 3'd2,
        PH_RECV = 3'd3,
        PH_CMP  = 3'd4
    } phase_e;

    localparam int unsigned BIT_GO     = 7;
    localparam int unsigned BIT_LOADED = 6;
    localparam int unsigned BIT_SENT   = 5;
    localparam int unsigned BIT_RXFULL = 4;
    localparam int unsigned BIT_CMP    = 3;
    localparam int unsigned BIT_RXERR  = 2;
    localparam int unsigned BIT_PASS   = 0;

endpackage

// File: rtl/ubist_copy_buf.sv
// Private copy of the bytes sent, read back in push order for comparison.
module ubist_copy_buf #(
    parameter  int DW    = 8,
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [DW-1:0] rd_data,
    output logic          wr_last,
    output logic          rd_last,
    output logic          miss_any
);

    typedef struct packed {
        logic [IW-1:0] widx;
        logic [IW-1:0] ridx;
        logic          wdone;
        logic          rdone;
        logic          miss;
    } buf_st_t;

    buf_st_t       st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          diff_now;

    always_comb begin
        st_d     = st_q;
        diff_now = rd_en && (mem_q[st_q.ridx] != rd_data);
        if (clr) begin
            st_d = '0;
        end else begin
            if (wr_en) begin
                if (st_q.widx == IW'(DEPTH - 1)) st_d.wdone = 1'b1;
                else                             st_d.widx  = st_q.widx + 1'b1;
            end
            if (rd_en) begin
                if (st_q.ridx == IW'(DEPTH - 1)) st_d.rdone = 1'b1;
                else                             st_d.ridx  = st_q.ridx + 1'b1;
                if (diff_now) st_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.widx] <= wr_data;
    end

    assign wr_last  = (st_q.widx == IW'(DEPTH - 1));
    assign rd_last  = (st_q.ridx == IW'(DEPTH - 1));
    assign miss_any = st_q.miss | diff_now;

    AST_NO_EXTRA_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !st_q.wdone); // R2
    AST_NO_EXTRA_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !st_q.rdone); // R5

endmodule

// File: rtl/ubist_timer.sv
// Watchdog counting cycles while the serial path is awaited.
module ubist_timer #(
    parameter  int unsigned LIMIT = 100,
    localparam int          CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        expired = run && (st_q.cnt == CW'(LIMIT - 1));
        if (!run)         st_d.cnt = '0;
        else if (!expired) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TMR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (st_q.cnt == '0)); // R7

endmodule

// File: rtl/ubist_seq.sv
// Phase sequencer and control/result register.
module ubist_seq
    import ubist_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_wr_data,
    output logic [7:0]       ctl_q,
    output logic             loop_en,
    output logic             pat_req,
    input  logic             pat_vld,
    output logic             txf_push,
    input  logic             tx_idle,
    input  logic [CNT_W-1:0] rxf_count,
    output logic             rxf_pop,
    input  logic             rx_err,
    input  logic             buf_wr_last,
    input  logic             buf_rd_last,
    input  logic             buf_miss,
    output logic             buf_clr,
    input  logic             tmr_expired,
    output logic             tmr_run
);

    typedef struct packed {
        phase_e     phase;
        logic [7:0] ctl;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic    start;

    always_comb begin
        st_d     = st_q;
        start    = cfg_wr_en && cfg_wr_data[BIT_GO] && (st_q.phase == PH_IDLE);
        pat_req  = 1'b0;
        txf_push = 1'b0;
        rxf_pop  = 1'b0;
        tmr_run  = 1'b0;
        buf_clr  = start;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.ctl   = 8'h80;
                    st_d.phase = PH_LOAD;
                end
            end
            PH_LOAD: begin
                pat_req = 1'b1;
                if (pat_vld) begin
                    txf_push = 1'b1;
                    if (buf_wr_last) begin
                        st_d.ctl[BIT_LOADED] = 1'b1;
                        st_d.phase           = PH_SEND;
                    end
                end
            end
            PH_SEND: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    st_d.ctl[BIT_GO] = 1'b0;
                    st_d.phase       = PH_IDLE;
                end else if (tx_idle) begin
                    st_d.ctl[BIT_SENT] = 1'b1;
                    st_d.phase         = PH_RECV;
                end
            end
            PH_RECV: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    st_d.ctl[BIT_GO] = 1'b0;
                    st_d.phase       = PH_IDLE;
                end else if (rxf_count >= CNT_W'(DEPTH)) begin
                    st_d.ctl[BIT_RXFULL] = 1'b1;
                    st_d.ctl[BIT_CMP]    = 1'b1;
                    st_d.phase           = PH_CMP;
                end
            end
            PH_CMP: begin
                rxf_pop = 1'b1;
                if (buf_rd_last) begin
                    st_d.ctl[BIT_PASS] = !buf_miss;
                    st_d.ctl[BIT_GO]   = 1'b0;
                    st_d.phase         = PH_IDLE;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.ctl   = 8'h00;
            end
        endcase

        if ((st_q.phase != PH_IDLE) && rx_err) st_d.ctl[BIT_RXERR] = 1'b1;
        st_d.ctl[1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.ctl   <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q   = st_q.ctl;
    assign loop_en = (st_q.phase != PH_IDLE);

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_wr_data[7] && !ctl_q[7]) |=> (ctl_q == 8'h80)); // R1
    AST_LOOP_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7] |-> loop_en); // R1
    AST_SENT_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[5] |-> ctl_q[6]); // R3
    AST_RXFULL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> (ctl_q[5] && ctl_q[3])); // R4
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop |-> (rxf_count != '0)); // R5
    AST_PASS_AFTER_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[0] |-> (ctl_q[3] && !ctl_q[7])); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[7] && ctl_q[2]) |=> ctl_q[2]); // R6
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[7] && !(cfg_wr_en && cfg_wr_data[7])) |=> $stable(ctl_q)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |-> (!txf_push && !rxf_pop)); // R11

endmodule

// File: rtl/uart_selftest_ctrl.sv
module uart_selftest_ctrl
    import ubist_pkg::*;
#(
    parameter  int DW          = 8,
    parameter  int DEPTH       = 16,
    parameter  int FRAME_CYC   = 57288,
    parameter  int FRAME_SLACK = 4,
    localparam int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [7:0]       cfg_wr_data,
    output logic [7:0]       cfg_rd_data,
    output logic             loop_en,
    output logic             pat_req,
    input  logic             pat_vld,
    input  logic [DW-1:0]    pat_data,
    output logic             txf_push,
    output logic [DW-1:0]    txf_data,
    input  logic             tx_idle,
    input  logic [CNT_W-1:0] rxf_count,
    input  logic [DW-1:0]    rxf_data,
    output logic             rxf_pop,
    input  logic             rx_err
);

    localparam int unsigned WAIT_LIMIT = FRAME_CYC * (DEPTH + FRAME_SLACK);

    logic buf_wr_last, buf_rd_last, buf_miss, buf_clr;
    logic tmr_run, tmr_expired;

    assign txf_data = pat_data;

    ubist_seq #(.DEPTH(DEPTH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .ctl_q       (cfg_rd_data),
        .loop_en     (loop_en),
        .pat_req     (pat_req),
        .pat_vld     (pat_vld),
        .txf_push    (txf_push),
        .tx_idle     (tx_idle),
        .rxf_count   (rxf_count),
        .rxf_pop     (rxf_pop),
        .rx_err      (rx_err),
        .buf_wr_last (buf_wr_last),
        .buf_rd_last (buf_rd_last),
        .buf_miss    (buf_miss),
        .buf_clr     (buf_clr),
        .tmr_expired (tmr_expired),
        .tmr_run     (tmr_run)
    );

    ubist_copy_buf #(.DW(DW), .DEPTH(DEPTH)) u_copy (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (txf_push),
        .wr_data  (pat_data),
        .rd_en    (rxf_pop),
        .rd_data  (rxf_data),
        .wr_last  (buf_wr_last),
        .rd_last  (buf_rd_last),
        .miss_any (buf_miss)
    );

    ubist_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_expired)
    );

endmodule

// File: tb/sim_uart_selftest_ctrl.sv
module sim_uart_selftest_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = $clog2(DEPTH + 1);
    localparam int BIT_CYC    = 8;
    localparam int WD_CYCLES  = 30000;

    // mode flags: bit0 corrupt byte idx, bit1 error pulse at idx, bit2 drop byte idx
    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] seed;
        logic [4:0] idx;
        logic       stall;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{3'b000, 8'hA5, 5'd0,  1'b0, 8'h79},
        '{3'b000, 8'h3C, 5'd0,  1'b1, 8'h79},
        '{3'b001, 8'h5A, 5'd0,  1'b0, 8'h78},
        '{3'b001, 8'hC3, 5'd15, 1'b1, 8'h78},
        '{3'b010, 8'h11, 5'd7,  1'b0, 8'h7D},
        '{3'b100, 8'h81, 5'd4,  1'b0, 8'h60},
        '{3'b011, 8'h2B, 5'd15, 1'b0, 8'h7C}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_en = 1'b0;
    logic [7:0]       cfg_wr_data = 8'h00;
    logic [7:0]       cfg_rd_data;
    logic             loop_en, pat_req, pat_vld, txf_push, tx_idle, rxf_pop, rx_err;
    logic [DW-1:0]    pat_data, txf_data, rxf_data;
    logic [CNT_W-1:0] rxf_count;

    // behavioural UART model controls
    logic       mdl_clr = 1'b1;
    logic [2:0] mdl_mode = 3'b000;
    logic [4:0] mdl_idx = 5'd0;
    logic       mdl_stall = 1'b0;
    logic [7:0] lfsr = 8'h01;
    logic [7:0] txq [32];
    logic [7:0] rxq [32];
    logic [5:0] tx_wr, tx_rd, rx_wr, rx_rd;
    logic [5:0] sent;
    int         busy;
    logic [7:0] cur;
    logic       err_pulse;
    int         cyc = 0;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign pat_vld   = pat_req && (!mdl_stall || cyc[0]);
    assign pat_data  = lfsr;
    assign tx_idle   = (tx_rd == tx_wr) && (busy == 0);
    assign rxf_count = CNT_W'(rx_wr - rx_rd);
    assign rxf_data  = rxq[rx_rd[4:0]];
    assign rx_err    = err_pulse;

    always @(posedge clk) begin
        if (pat_req && pat_vld) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mdl_clr) begin
            tx_wr <= '0; tx_rd <= '0; rx_wr <= '0; rx_rd <= '0;
            sent <= '0; busy <= 0; err_pulse <= 1'b0; cur <= '0;
        end else begin
            err_pulse <= 1'b0;
            if (txf_push) begin
                txq[tx_wr[4:0]] <= txf_data;
                tx_wr <= tx_wr + 1'b1;
            end
            if (rxf_pop) rx_rd <= rx_rd + 1'b1;
            if (busy == 0) begin
                if (tx_rd != tx_wr) begin
                    cur   <= txq[tx_rd[4:0]];
                    tx_rd <= tx_rd + 1'b1;
                    busy  <= BIT_CYC;
                end
            end else begin
                busy <= busy - 1;
                if (busy == 1) begin
                    sent <= sent + 1'b1;
                    if (loop_en && !(mdl_mode[2] && sent == {1'b0, mdl_idx})) begin
                        rxq[rx_wr[4:0]] <= cur ^ ((mdl_mode[0] && sent == {1'b0, mdl_idx}) ? 8'h01 : 8'h00);
                        rx_wr <= rx_wr + 1'b1;
                    end
                    if (mdl_mode[1] && sent == {1'b0, mdl_idx}) err_pulse <= 1'b1;
                end
            end
        end
    end

    uart_selftest_ctrl #(
        .DW(DW), .DEPTH(DEPTH), .FRAME_CYC(10), .FRAME_SLACK(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .loop_en(loop_en), .pat_req(pat_req), .pat_vld(pat_vld), .pat_data(pat_data),
        .txf_push(txf_push), .txf_data(txf_data), .tx_idle(tx_idle),
        .rxf_count(rxf_count), .rxf_data(rxf_data), .rxf_pop(rxf_pop), .rx_err(rx_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic wait_bit(input int b, input logic lvl);
        for (int i = 0; i < 2000; i++) begin
            if (cfg_rd_data[b] == lvl) break;
            @(negedge clk);
        end
    endtask

    task automatic prep(input logic [2:0] mode, input logic [7:0] seed,
                        input logic [4:0] idx, input logic stall);
        @(negedge clk);
        mdl_mode = mode; mdl_idx = idx; mdl_stall = stall; mdl_clr = 1'b1;
        @(negedge clk);
        mdl_clr = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 reg", cfg_rd_data, 8'h00);
        check("R11 loop_en", loop_en, 0);
        check("R11 push/pop", {txf_push, rxf_pop}, 0);

        // R9 write without start bit in idle
        cfg_write(8'h7F);
        check("R9 no-start write", cfg_rd_data, 8'h00);

        // directed clean run with phase observation
        prep(3'b000, 8'h77, 5'd0, 1'b0);
        cfg_write(8'h80);
        check("R1 start value", cfg_rd_data, 8'h80);
        check("R1 loopback on", loop_en, 1);
        wait_bit(6, 1'b1);
        check("R2 loaded bits", cfg_rd_data, 8'hC0);
        check("R2 push count", int'(tx_wr), DEPTH);
        cfg_write(8'h00);
        check("R9 busy write ignored", cfg_rd_data[7:6], 2'b11);
        cfg_write(8'hFF);
        check("R9 busy start ignored", cfg_rd_data[4:0], 0);
        wait_bit(5, 1'b1);
        check("R3 sent with tx idle", tx_idle, 1);
        check("R3 bit4 not yet", cfg_rd_data[4], 0);
        wait_bit(4, 1'b1);
        check("R4 cmp bit with rxfull", cfg_rd_data[3], 1);
        check("R4 rx level", int'(rxf_count), DEPTH);
        wait_bit(7, 1'b0);
        check("R8 final value", cfg_rd_data, 8'h79);
        check("R10 bit1 zero", cfg_rd_data[1], 0);
        check("R5 all popped", int'(rxf_count), 0);
        check("R1 loopback off", loop_en, 0);
        repeat (40) @(negedge clk);
        check("R8 result held", cfg_rd_data, 8'h79);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            prep(VECS[v].mode, VECS[v].seed, VECS[v].idx, VECS[v].stall);
            lfsr = VECS[v].seed;
            cfg_write(8'h80);
            check("R1 restart clears", cfg_rd_data, 8'h80);
            wait_bit(7, 1'b0);
            if (VECS[v].mode[2])      check("R7 timeout result", cfg_rd_data, VECS[v].exp);
            else if (VECS[v].mode[1]) check("R6 error flag", cfg_rd_data, VECS[v].exp);
            else                      check("R5 compare result", cfg_rd_data, VECS[v].exp);
            check("R10 bit1 zero", cfg_rd_data[1], 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule